// File: doc/BRIEF.md
# Half-Step Predivider Clock Generator

This block makes one programmable divided clock, for example a pixel clock or an audio master clock. Three reference sources are offered. Each arrives as a one-cycle enable pulse on a single fast system clock. A 16-bit control word chooses one source and a predivide step of 2, 2.5 or 3 source periods. It also sets an integer count of such steps per output period, and an enable. The output is a register in the fast clock domain, so it is free of glitches by construction.

A new control word never cuts the running period short. Source, predivider and divider move into the active set only when the output starts its next period. Clearing the enable lets the current high phase finish and then parks the output low. An illegal word raises `config_error` and keeps the output from starting.

Top module: `halfstep_clkgen`

## Requirements
- R1: The control word holds the divider in bits 6:0, the predivide code in bits 9:8, the PLL choice in bit 13, the external choice in bit 14 and the enable in bit 15. A write replaces the whole word. Bits 7 and 12:10 have no effect on the output.
- R2: When bit 14 is clear, source tick 0 is counted. When bit 14 is set, bit 13 picks tick 2 (set) or tick 1 (clear).
- R3: Two consecutive output periods together last (code+3)*divider ticks of the selected source.
- R4: Code 2 builds its steps alternately from 2 and 3 source ticks. With an even divider, each period is 2.5*divider ticks. With an odd divider, consecutive periods differ by exactly one tick.
- R5: The high phase lasts floor(divider/2) predivide steps. Each step is 2 ticks with code 1 and 3 ticks with code 3. The low phase lasts the remaining steps.
- R6: A divider below 2 or a code of 0 is illegal. `config_error` is high in the cycle after such a write. A stopped output does not start. A running output stops low at the end of its current period.
- R7: A new legal word takes effect at the next rising edge of the output. The period in progress keeps its old source, code and divider.
- R8: Clearing the enable during a high phase lets that phase finish to its full length. The output then stays low. Clearing it during a low phase keeps the output low from then on.
- R9: After reset, `clk_out` is low and `config_error` is high, because the word resets to zero.
- R10: From the stopped state, a legal enabled word drives `clk_out` high one cycle after the word is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word written on `cfg_we` |
| src_tick | input | 3 | One-cycle enable pulses of the three reference sources |
| clk_out | output | 1 | Divided clock |
| config_error | output | 1 | Stored word is illegal |

## Verification
The hardest cases to reach are a control write landing inside a period that is already running, and a disable landing inside a high phase. Both depend on where the output sits in its cycle. The bench waits for an observed rising edge and writes a few cycles later. It then times the remainder of that period, and the next one, against the old and new settings. The alternating 2/3 pattern only shows as a one-tick difference between neighbouring periods with odd dividers. The sweep therefore runs sources with different tick spacings and compares single periods and period pairs for every code and divider.

// File: rtl/hs_clkgen_pkg.sv
package hs_clkgen_pkg;
  localparam int DIV_W  = 7;
  localparam int PRE_W  = 2;
  localparam int NSRC   = 3;
  localparam int SEL_W  = $clog2(NSRC);
  localparam int SLOT_W = 2;
  localparam int REG_W  = 16;

  typedef struct packed {
    logic             en;
    logic             ext_sel;
    logic             pll_sel;
    logic [2:0]       spare_hi;
    logic [PRE_W-1:0] pre_code;
    logic             spare_lo;
    logic [DIV_W-1:0] div;
  } cfg_t;

  // legal: integer divider of at least two and a non-zero predivide code
  function automatic logic cfg_legal(cfg_t c);
    return (c.div >= DIV_W'(2)) && (c.pre_code != PRE_W'(0));
  endfunction

  // source ticks per predivide step; code 2 alternates 2 and 3
  function automatic logic [SLOT_W-1:0] slot_len(logic [PRE_W-1:0] code, logic alt);
    case (code)
      PRE_W'(1): return SLOT_W'(2);
      PRE_W'(2): return alt ? SLOT_W'(3) : SLOT_W'(2);
      PRE_W'(3): return SLOT_W'(3);
      default:   return SLOT_W'(2);
    endcase
  endfunction

  // steps spent high in one output period
  function automatic logic [DIV_W-1:0] hi_slots(logic [DIV_W-1:0] d);
    return d >> 1;
  endfunction

  function automatic logic [SEL_W-1:0] src_index(logic ext, logic pll);
    return ext ? (pll ? SEL_W'(2) : SEL_W'(1)) : SEL_W'(0);
  endfunction
endpackage

// File: rtl/hs_src_mux.sv
module hs_src_mux #(
  parameter int N_SRC = 3,
  localparam int SW = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] ticks,
  input  logic [SW-1:0]    sel,
  output logic             tick
);
  logic [N_SRC-1:0] hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign hit[g] = ticks[g] && (sel == SW'(g));
  end

  assign tick = |hit;
endmodule

// File: rtl/hs_prediv.sv
module hs_prediv
  import hs_clkgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [PRE_W-1:0] code,
  output logic             pulse
);
  logic [SLOT_W-1:0] cnt;
  logic              alt;
  logic [SLOT_W-1:0] len;
  logic              last;

  assign len   = slot_len(code, alt);
  assign last  = (cnt == len - SLOT_W'(1));
  assign pulse = run && tick && last;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      alt <= 1'b0;
    end else if (tick) begin
      if (last) begin
        cnt <= '0;
        alt <= ~alt;   // keeps alternating across output periods
      end else begin
        cnt <= cnt + SLOT_W'(1);
      end
    end
  end
endmodule

// File: rtl/hs_divider.sv
module hs_divider
  import hs_clkgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pulse,
  input  logic [DIV_W-1:0] div,
  output logic             period_end,
  output logic             hi_end
);
  logic [DIV_W-1:0] cnt;

  assign period_end = pulse && (cnt == div - DIV_W'(1));
  assign hi_end     = pulse && (cnt == hi_slots(div) - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run)   cnt <= '0;
    else if (period_end)  cnt <= '0;
    else if (pulse)       cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/halfstep_clkgen.sv
module halfstep_clkgen
  import hs_clkgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic [NSRC-1:0]  src_tick,
  output logic             clk_out,
  output logic             config_error
);
  cfg_t             cfg_q;
  logic [DIV_W-1:0] act_div;
  logic [PRE_W-1:0] act_code;
  logic [SEL_W-1:0] act_sel;
  logic             running;
  logic             clk_q;

  // named internal events
  logic             start_ok;
  logic             sel_tick;
  logic             pre_pulse;
  logic             period_end;
  logic             hi_end;

  assign start_ok     = cfg_q.en && cfg_legal(cfg_q);
  assign config_error = !cfg_legal(cfg_q);
  assign clk_out      = clk_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_t'(cfg_wdata);
  end

  hs_src_mux #(.N_SRC(NSRC)) i_mux (
    .ticks (src_tick),
    .sel   (act_sel),
    .tick  (sel_tick)
  );

  hs_prediv i_prediv (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (running),
    .tick  (sel_tick),
    .code  (act_code),
    .pulse (pre_pulse)
  );

  hs_divider i_divider (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (running),
    .pulse      (pre_pulse),
    .div        (act_div),
    .period_end (period_end),
    .hi_end     (hi_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      clk_q    <= 1'b0;
      act_div  <= DIV_W'(2);
      act_code <= PRE_W'(1);
      act_sel  <= '0;
    end else if (!running) begin
      if (start_ok) begin
        running  <= 1'b1;
        clk_q    <= 1'b1;
        act_div  <= cfg_q.div;
        act_code <= cfg_q.pre_code;
        act_sel  <= src_index(cfg_q.ext_sel, cfg_q.pll_sel);
      end
    end else if (period_end) begin
      if (start_ok) begin
        clk_q    <= 1'b1;
        act_div  <= cfg_q.div;
        act_code <= cfg_q.pre_code;
        act_sel  <= src_index(cfg_q.ext_sel, cfg_q.pll_sel);
      end else begin
        running <= 1'b0;
        clk_q   <= 1'b0;
      end
    end else if (hi_end) begin
      clk_q <= 1'b0;
      if (!cfg_q.en) running <= 1'b0;
    end else if (!clk_q && !cfg_q.en) begin
      running <= 1'b0;
    end
  end
endmodule

// File: rtl/hs_clkgen_checker.sv
module hs_clkgen_checker
  import hs_clkgen_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input cfg_t             cfg_word,
  input logic             clk_out,
  input logic             config_error,
  input logic             running,
  input logic             period_end,
  input logic             hi_end,
  input logic             start_ok,
  input logic [DIV_W-1:0] act_div
);
  p_reg_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_word));

  p_rise_on_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out) |-> $past(period_end || !running));

  p_fall_on_phase_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_out) |-> $past(hi_end || period_end));

  p_active_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !$past(period_end)) |-> $stable(act_div));

  p_err_no_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && config_error) |=> !clk_out);

  p_div_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (act_div >= DIV_W'(2)));

  p_off_stays_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start_ok) |=> !clk_out);
endmodule

bind halfstep_clkgen hs_clkgen_checker i_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .cfg_word     (cfg_q),
  .clk_out      (clk_out),
  .config_error (config_error),
  .running      (running),
  .period_end   (period_end),
  .hi_end       (hi_end),
  .start_ok     (start_ok),
  .act_div      (act_div)
);

// File: tb/test_halfstep_clkgen.sv
module test_halfstep_clkgen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [2:0]  src_tick;
  logic        clk_out;
  logic        config_error;

  int cyc = 0;
  int ph1 = 0;
  int ph2 = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // source k ticks every k+1 fast cycles
  always @(posedge clk) begin
    cyc <= cyc + 1;
    ph1 <= (ph1 + 1) % 2;
    ph2 <= (ph2 + 1) % 3;
  end
  assign src_tick = {ph2 == 0, ph1 == 0, 1'b1};

  halfstep_clkgen i_halfstep_clkgen (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .src_tick     (src_tick),
    .clk_out      (clk_out),
    .config_error (config_error)
  );

  // R1 layout: div 6:0, code 9:8, pll 13, ext 14, enable 15, spare 7 and 12:10
  function automatic logic [15:0] mk(bit en, int src, int code, int d, bit spare);
    logic [15:0] v;
    v = '0;
    v[15]  = en;
    v[14]  = (src != 0);
    v[13]  = (src == 2);
    v[9:8] = code[1:0];
    v[6:0] = d[6:0];
    if (spare) begin
      v[12:10] = 3'b111;
      v[7]     = 1'b1;
    end
    return v;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(logic [15:0] v);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic wait_rise(output int t);
    logic last;
    last = clk_out;
    while (1) begin
      @(negedge clk);
      if (clk_out && !last) break;
      last = clk_out;
    end
    t = cyc;
  endtask

  task automatic wait_fall(output int t);
    logic last;
    last = clk_out;
    while (1) begin
      @(negedge clk);
      if (!clk_out && last) break;
      last = clk_out;
    end
    t = cyc;
  endtask

  task automatic expect_quiet(int n, string req);
    int highs;
    highs = 0;
    repeat (n) begin
      @(negedge clk);
      if (clk_out) highs++;
    end
    check(highs == 0, req, highs, 0);
  endtask

  task automatic go_idle();
    write_cfg(16'h0000);
    while (clk_out) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      summary();
    end
  end

  initial begin
    int divs[9];
    int r0, r1, r2, r3, r4, f1;
    divs = '{2, 3, 4, 5, 6, 7, 9, 16, 127};

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9
    check(clk_out == 1'b0, "R9 clk_out", clk_out, 0);
    check(config_error == 1'b1, "R9 config_error", config_error, 1);

    // sweep over sources (R2), codes and dividers
    for (int s = 0; s < 3; s++) begin
      for (int code = 1; code <= 3; code++) begin
        for (int di = 0; di < 9; di++) begin
          int d, n, two, slot;
          d = divs[di];
          n = s + 1;
          two = (code + 3) * d * n;
          write_cfg(mk(1'b1, s, code, d, di % 2 == 1));
          @(negedge clk);
          check(clk_out == 1'b1, "R10 start", clk_out, 1);
          wait_rise(r1);
          wait_fall(f1);
          wait_rise(r2);
          wait_rise(r3);
          check(r3 - r1 == two, "R3 R2 R1 two periods", r3 - r1, two);
          if (code != 2) begin
            slot = (code == 1) ? 2 : 3;
            check(r2 - r1 == two / 2, "R3 R1 single period", r2 - r1, two / 2);
            check(f1 - r1 == (d / 2) * slot * n, "R5 high phase", f1 - r1, (d / 2) * slot * n);
          end else if (d % 2 == 0) begin
            check((r2 - r1 == 5 * d * n / 2) && (r3 - r2 == 5 * d * n / 2),
                  "R4 even divider", r2 - r1, 5 * d * n / 2);
          end else begin
            int df;
            df = (r2 - r1) - (r3 - r2);
            if (df < 0) df = -df;
            check(df == n, "R4 odd divider alternation", df, n);
          end
          go_idle();
        end
      end
    end

    // R6 illegal words from idle
    write_cfg(mk(1'b1, 0, 1, 1, 1'b0));
    check(config_error == 1'b1, "R6 div 1 flag", config_error, 1);
    expect_quiet(40, "R6 div 1 quiet");
    write_cfg(mk(1'b1, 0, 0, 5, 1'b0));
    check(config_error == 1'b1, "R6 code 0 flag", config_error, 1);
    expect_quiet(40, "R6 code 0 quiet");
    write_cfg(mk(1'b1, 0, 1, 0, 1'b0));
    check(config_error == 1'b1, "R6 div 0 flag", config_error, 1);
    expect_quiet(40, "R6 div 0 quiet");

    // R6 illegal word while running: period finishes, then stops
    write_cfg(mk(1'b1, 0, 1, 4, 1'b0));
    check(config_error == 1'b0, "R6 legal flag", config_error, 0);
    wait_rise(r0);
    write_cfg(mk(1'b1, 0, 1, 1, 1'b0));
    wait_fall(f1);
    check(f1 - r0 == 4, "R6 current high phase kept", f1 - r0, 4);
    expect_quiet(60, "R6 stops after period");
    go_idle();

    // R7 reconfiguration lands at the next rising edge
    write_cfg(mk(1'b1, 0, 1, 4, 1'b0));
    wait_rise(r0);
    write_cfg(mk(1'b1, 0, 1, 6, 1'b0));
    wait_rise(r1);
    check(r1 - r0 == 8, "R7 old period kept", r1 - r0, 8);
    wait_rise(r2);
    check(r2 - r1 == 12, "R7 new divider", r2 - r1, 12);
    write_cfg(mk(1'b1, 2, 1, 6, 1'b0));
    wait_rise(r3);
    check(r3 - r2 == 12, "R7 R2 old source kept", r3 - r2, 12);
    wait_rise(r4);
    check(r4 - r3 == 36, "R7 R2 new source", r4 - r3, 36);
    go_idle();

    // R8 disable inside a high phase
    write_cfg(mk(1'b1, 0, 1, 8, 1'b0));
    wait_rise(r0);
    write_cfg(mk(1'b0, 0, 1, 8, 1'b0));
    wait_fall(f1);
    check(f1 - r0 == 8, "R8 high phase completes", f1 - r0, 8);
    check(config_error == 1'b0, "R8 no error", config_error, 0);
    expect_quiet(60, "R8 stays low");

    // R8 disable inside a low phase
    write_cfg(mk(1'b1, 0, 3, 5, 1'b0));
    wait_fall(f1);
    write_cfg(mk(1'b0, 0, 3, 5, 1'b0));
    expect_quiet(60, "R8 low phase disable");

    summary();
  end
endmodule